// File: doc/BRIEF.md
# Tile row pixel extractor

This block sits between the graphics ROMs and a priority mixer in a tile-based video pipeline. For each of three scrolling layers (two playfields and a fixed text layer) it catches a 32-bit ROM word holding one row of eight 4-bit pixels. It then hands out one pixel per layer on every pixel step. The three rows arrive one after another on a single shared ROM bus, each qualified by its own strobe. Each strobe also carries the tile's horizontal mirror bit and a palette attribute for that layer.

A captured row waits in a capture latch until the pixel counter crosses an 8-pixel boundary. At that boundary all three rows move together into holding registers. The layers keep emitting pixels from their held rows while the next three fetches land in the capture latches. On every pixel step the block chooses one nibble per layer using the shared pixel counter, that layer's fine horizontal scroll and the mirror state. The three codes, with their attributes, come out together on registered outputs.

Top module: `tile_pixel_extractor`

## Requirements
- R1: A synchronous active-high reset clears every capture latch, holding register, attribute, the pixel counter and all outputs. After reset `pix_code`, `pix_attr` and `pix_valid` read zero.
- R2: A cycle with `row_strobe[l]` high stores `rom_data`, `row_hflip` and `row_attr` into layer l's capture latch only (bit 0 = layer A, bit 1 = layer B, bit 2 = FIX layer). The stored attribute appears on that layer's `pix_attr` slice for every pixel taken from that row.
- R3: On a `pix_en` cycle in which the pixel counter is 7, every capture latch is copied into its holding register. A capture at any other time leaves the pixels currently being emitted unchanged.
- R4: Layer l's pixel index is (counter + `fine_x[3l+2:3l]`) mod 8. Pixel n of a row sits in bits 4n+3:4n of the word.
- R5: When exactly one of `flip_screen` and the held row's mirror bit is set, the index from R4 is XORed with 7. When both are set, the mirroring cancels.
- R6: All three codes and attributes change in the same cycle, one clock after a `pix_en` cycle. The counter advances by one only on `pix_en`. Without `pix_en`, outputs and counter hold and `pix_valid` is low.
- R7: `pix_valid` is high for one cycle after a `pix_en` cycle, and only once all three holding registers have received a row since reset.
- R8: A pixel code of 0 passes to the output as 0, unaltered, together with its layer attribute, so the mixer can treat it as transparent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel step enable |
| rom_data | input | 32 | Shared graphics ROM row word |
| row_strobe | input | 3 | Per-layer capture strobe |
| row_hflip | input | 1 | Mirror bit for the row being captured |
| row_attr | input | 4 | Palette attribute for the row being captured |
| fine_x | input | 9 | Fine horizontal scroll, 3 bits per layer |
| flip_screen | input | 1 | Whole-display horizontal flip |
| pix_code | output | 12 | Selected 4-bit code per layer, layer l in bits 4l+3:4l |
| pix_attr | output | 12 | Attribute per layer, layer l in bits 4l+3:4l |
| pix_valid | output | 1 | Pixel step result valid |

## Verification
The bench strobes new rows into the capture latches in the middle of a row. A design that moved captures straight into the selection path would show the wrong row before the boundary. It also loads only two layers for a full row period. A design that raised `pix_valid` on partial data would flag pixels for a layer that was never fetched. Vectors with screen flip and tile mirror both set catch an OR where an XOR is needed. Idle gaps with fresh strobes expose outputs that move without `pix_en`. A reset in the middle of a row exposes a counter that keeps its phase across reset.

// File: rtl/tpx_pkg.sv
package tpx_pkg;
  localparam int unsigned TPX_LAYERS  = 3;
  localparam int unsigned TPX_PIX_W   = 4;
  localparam int unsigned TPX_ROW_PIX = 8;
  localparam int unsigned TPX_ATTR_W  = 4;

  // Index width for a row of n pixels (n a power of two).
  function automatic int unsigned tpx_idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tpx_row_store.sv
// Capture latch plus holding register for one layer's tile row.
module tpx_row_store #(
  parameter int unsigned ROW_W  = 32,
  parameter int unsigned ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [ROW_W-1:0]  row_in,
  input  logic              hflip_in,
  input  logic [ATTR_W-1:0] attr_in,
  input  logic              xfer,
  output logic [ROW_W-1:0]  hold_row,
  output logic              hold_hflip,
  output logic [ATTR_W-1:0] hold_attr,
  output logic              hold_full
);
  logic [ROW_W-1:0]  cap_row;
  logic              cap_hflip;
  logic [ATTR_W-1:0] cap_attr;
  logic              cap_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_row    <= '0;
      cap_hflip  <= 1'b0;
      cap_attr   <= '0;
      cap_full   <= 1'b0;
      hold_row   <= '0;
      hold_hflip <= 1'b0;
      hold_attr  <= '0;
      hold_full  <= 1'b0;
    end else begin
      if (cap_en) begin
        cap_row   <= row_in;
        cap_hflip <= hflip_in;
        cap_attr  <= attr_in;
        cap_full  <= 1'b1;
      end
      // Transfer takes the latch contents from before this edge.
      if (xfer) begin
        hold_row   <= cap_row;
        hold_hflip <= cap_hflip;
        hold_attr  <= cap_attr;
        hold_full  <= cap_full;
      end
    end
  end
endmodule

// File: rtl/tpx_pixel_pick.sv
// Combinational nibble select with fine scroll and mirroring.
module tpx_pixel_pick #(
  parameter int unsigned PIX_W   = 4,
  parameter int unsigned ROW_PIX = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [PIX_W*ROW_PIX-1:0] row,
  input  logic [IDX_W-1:0]         base,
  input  logic [IDX_W-1:0]         fine,
  input  logic                     mirror,
  output logic [PIX_W-1:0]         code
);
  logic [IDX_W-1:0] sum;
  logic [IDX_W-1:0] idx;

  always_comb begin
    sum  = base + fine;
    idx  = sum ^ {IDX_W{mirror}};
    code = row[idx*PIX_W +: PIX_W];
  end
endmodule

// File: rtl/tpx_pixel_counter.sv
// Pixel position within the current 8-pixel row period.
module tpx_pixel_counter #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [IDX_W-1:0] cnt,
  output logic             at_last
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  assign at_last = &cnt;
endmodule

// File: rtl/tile_pixel_extractor.sv
module tile_pixel_extractor
  import tpx_pkg::*;
#(
  parameter int unsigned NUM_LAYERS = TPX_LAYERS,
  parameter int unsigned PIX_W      = TPX_PIX_W,
  parameter int unsigned ROW_PIX    = TPX_ROW_PIX,
  parameter int unsigned ATTR_W     = TPX_ATTR_W,
  localparam int unsigned ROW_W     = PIX_W * ROW_PIX,
  localparam int unsigned IDX_W     = tpx_idx_w(ROW_PIX)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pix_en,
  input  logic [ROW_W-1:0]             rom_data,
  input  logic [NUM_LAYERS-1:0]        row_strobe,
  input  logic                         row_hflip,
  input  logic [ATTR_W-1:0]            row_attr,
  input  logic [NUM_LAYERS*IDX_W-1:0]  fine_x,
  input  logic                         flip_screen,
  output logic [NUM_LAYERS*PIX_W-1:0]  pix_code,
  output logic [NUM_LAYERS*ATTR_W-1:0] pix_attr,
  output logic                         pix_valid
);
  logic [IDX_W-1:0]      pix_cnt;
  logic                  last_slot;
  logic                  xfer;
  logic [NUM_LAYERS-1:0] hold_full;
  logic                  valid_q;

  tpx_pixel_counter #(.IDX_W(IDX_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .step    (pix_en),
    .cnt     (pix_cnt),
    .at_last (last_slot)
  );

  assign xfer = pix_en & last_slot;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    logic [ROW_W-1:0]  h_row;
    logic              h_hflip;
    logic [ATTR_W-1:0] h_attr;
    logic [PIX_W-1:0]  picked;
    logic [PIX_W-1:0]  code_q;
    logic [ATTR_W-1:0] attr_q;

    tpx_row_store #(.ROW_W(ROW_W), .ATTR_W(ATTR_W)) u_store (
      .clk        (clk),
      .rst        (rst),
      .cap_en     (row_strobe[l]),
      .row_in     (rom_data),
      .hflip_in   (row_hflip),
      .attr_in    (row_attr),
      .xfer       (xfer),
      .hold_row   (h_row),
      .hold_hflip (h_hflip),
      .hold_attr  (h_attr),
      .hold_full  (hold_full[l])
    );

    tpx_pixel_pick #(.PIX_W(PIX_W), .ROW_PIX(ROW_PIX), .IDX_W(IDX_W)) u_pick (
      .row    (h_row),
      .base   (pix_cnt),
      .fine   (fine_x[l*IDX_W +: IDX_W]),
      .mirror (flip_screen ^ h_hflip),
      .code   (picked)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= '0;
        attr_q <= '0;
      end else if (pix_en) begin
        code_q <= picked;
        attr_q <= h_attr;
      end
    end

    assign pix_code[l*PIX_W +: PIX_W]   = code_q;
    assign pix_attr[l*ATTR_W +: ATTR_W] = attr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= pix_en & (&hold_full);
  end

  assign pix_valid = valid_q;
endmodule

// File: rtl/tpx_checker.sv
module tpx_checker #(
  parameter int unsigned NUM_LAYERS = 3,
  parameter int unsigned PIX_W      = 4,
  parameter int unsigned IDX_W      = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        pix_en,
  input logic                        pix_valid,
  input logic [NUM_LAYERS*PIX_W-1:0] pix_code,
  input logic [IDX_W-1:0]            pix_cnt,
  input logic [NUM_LAYERS-1:0]       hold_full
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pix_valid && pix_code == '0 && pix_cnt == '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> pix_cnt == IDX_W'($past(pix_cnt) + 1'b1));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(pix_code) && $stable(pix_cnt) && !pix_valid));

  assert_valid_after_step_R7: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(pix_en));

  assert_valid_needs_rows_R7: assert property (@(posedge clk) disable iff (rst)
    !(&hold_full) |=> !pix_valid);
endmodule

bind tile_pixel_extractor tpx_checker #(
  .NUM_LAYERS (NUM_LAYERS),
  .PIX_W      (PIX_W),
  .IDX_W      (IDX_W)
) u_tpx_chk (
  .clk       (clk),
  .rst       (rst),
  .pix_en    (pix_en),
  .pix_valid (pix_valid),
  .pix_code  (pix_code),
  .pix_cnt   (pix_cnt),
  .hold_full (hold_full)
);

// File: tb/tb_tile_pixel_extractor.sv
module tb_tile_pixel_extractor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_en = 1'b0;
  logic [31:0] rom_data = '0;
  logic [2:0]  row_strobe = '0;
  logic        row_hflip = 1'b0;
  logic [3:0]  row_attr = '0;
  logic [8:0]  fine_x = '0;
  logic        flip_screen = 1'b0;
  logic [11:0] pix_code;
  logic [11:0] pix_attr;
  logic        pix_valid;

  int checks = 0;
  int failures = 0;

  // Bench model of the row storage.
  logic [31:0] m_cap  [3];
  logic [31:0] m_hold [3];
  logic [3:0]  m_cap_at [3];
  logic [3:0]  m_hold_at [3];
  logic [2:0]  m_cap_hf, m_hold_hf, m_cap_full, m_hold_full;
  int          m_cnt;

  // {rowA, rowB, rowFIX, fine{F,B,A}, flip, hflip{F,B,A}}
  localparam logic [108:0] VEC [6] = '{
    {32'h76543210, 32'hFEDCBA98, 32'h0A0B0C0D, 9'o000, 1'b0, 3'b000},
    {32'h13579BDF, 32'h02468ACE, 32'hF0E1D2C3, 9'o271, 1'b0, 3'b010},
    {32'h0000000F, 32'hF0000000, 32'h12345678, 9'o735, 1'b1, 3'b000},
    {32'hCAFE0123, 32'h89ABCDEF, 32'h00FF00FF, 9'o000, 1'b1, 3'b111},
    {32'h11112222, 32'h33334444, 32'h55556666, 9'o444, 1'b0, 3'b101},
    {32'h00000000, 32'h87654321, 32'hDEADBEEF, 9'o612, 1'b0, 3'b000}
  };

  tile_pixel_extractor dut (
    .clk         (clk),
    .rst         (rst),
    .pix_en      (pix_en),
    .rom_data    (rom_data),
    .row_strobe  (row_strobe),
    .row_hflip   (row_hflip),
    .row_attr    (row_attr),
    .fine_x      (fine_x),
    .flip_screen (flip_screen),
    .pix_code    (pix_code),
    .pix_attr    (pix_attr),
    .pix_valid   (pix_valid)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int l = 0; l < 3; l++) begin
      m_cap[l] = '0; m_hold[l] = '0; m_cap_at[l] = '0; m_hold_at[l] = '0;
    end
    m_cap_hf = '0; m_hold_hf = '0; m_cap_full = '0; m_hold_full = '0;
    m_cnt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pix_en = 1'b0; row_strobe = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    check("R1", "code after reset", 32'(pix_code), 32'h0);
    check("R1", "attr after reset", 32'(pix_attr), 32'h0);
    check("R1", "valid after reset", 32'(pix_valid), 32'h0);
  endtask

  task automatic strobe_layer(input int l, input logic [31:0] data,
                              input logic hf, input logic [3:0] at);
    @(negedge clk);
    rom_data = data; row_hflip = hf; row_attr = at;
    row_strobe = 3'(1 << l);
    m_cap[l] = data; m_cap_hf[l] = hf; m_cap_at[l] = at; m_cap_full[l] = 1'b1;
    @(negedge clk);
    row_strobe = '0;
    rom_data = 32'hA5A5A5A5;
  endtask

  task automatic pixel_step();
    logic [3:0] exp_code [3];
    logic [3:0] exp_attr [3];
    string      tag [3];
    logic       exp_valid;
    @(negedge clk);
    pix_en = 1'b1;
    for (int l = 0; l < 3; l++) begin
      int idx;
      idx = (m_cnt + int'(fine_x[l*3 +: 3])) % 8;
      if (flip_screen != m_hold_hf[l]) idx = 7 - idx;
      exp_code[l] = m_hold[l][idx*4 +: 4];
      exp_attr[l] = m_hold_at[l];
      tag[l] = (exp_code[l] == 4'h0) ? "R8" :
               ((flip_screen != m_hold_hf[l]) ? "R5" : "R4");
    end
    exp_valid = &m_hold_full;
    if (m_cnt == 7) begin
      for (int l = 0; l < 3; l++) begin
        m_hold[l] = m_cap[l]; m_hold_at[l] = m_cap_at[l];
      end
      m_hold_hf = m_cap_hf; m_hold_full = m_cap_full;
    end
    m_cnt = (m_cnt + 1) % 8;
    @(negedge clk);
    pix_en = 1'b0;
    for (int l = 0; l < 3; l++) begin
      check(tag[l], $sformatf("layer %0d code (R3 held row)", l),
            32'(pix_code[l*4 +: 4]), 32'(exp_code[l]));
      check("R2", $sformatf("layer %0d attr", l),
            32'(pix_attr[l*4 +: 4]), 32'(exp_attr[l]));
    end
    check("R7", "valid", 32'(pix_valid), 32'(exp_valid));
  endtask

  task automatic run_row();
    for (int k = 0; k < 8; k++) pixel_step();
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();

    // Table walk: new rows are captured in mid-row while the held rows play.
    for (int v = 0; v < 6; v++) begin
      logic [108:0] e;
      e = VEC[v];
      fine_x = e[12:4];
      flip_screen = e[3];
      for (int k = 0; k < 8; k++) begin
        pixel_step();
        if (k == 1) strobe_layer(0, e[108:77], e[0], 4'(v*3 + 1));
        if (k == 3) strobe_layer(1, e[76:45],  e[1], 4'(v*3 + 2));
        if (k == 5) strobe_layer(2, e[44:13],  e[2], 4'(v*3 + 3));
      end
    end
    fine_x = 9'o123;
    flip_screen = 1'b0;
    run_row();

    // R6: idle cycles with fresh strobes and changed scroll move nothing.
    pixel_step();
    begin
      logic [11:0] code_before;
      logic [11:0] attr_before;
      code_before = pix_code;
      attr_before = pix_attr;
      fine_x = 9'o765;
      strobe_layer(0, 32'h9999AAAA, 1'b1, 4'hE);
      @(negedge clk);
      check("R6", "codes stable while idle", 32'(pix_code), 32'(code_before));
      check("R6", "attrs stable while idle", 32'(pix_attr), 32'(attr_before));
      check("R6", "valid low while idle", 32'(pix_valid), 32'h0);
    end

    // R1: reset in the middle of a row restarts the counter phase.
    pixel_step();
    pixel_step();
    do_reset();
    fine_x = 9'o000;

    // R7: two layers only -> never valid; third layer completes the set.
    strobe_layer(0, 32'h0123ABCD, 1'b0, 4'h4);
    strobe_layer(1, 32'h10203040, 1'b1, 4'h5);
    run_row();
    run_row();
    check("R7", "valid with FIX never loaded", 32'(pix_valid), 32'h0);
    strobe_layer(2, 32'h00C0FFEE, 1'b0, 4'h6);
    run_row();
    // R2: only FIX was reloaded; A and B keep their rows in this period.
    run_row();
    check("R7", "valid with all layers loaded", 32'(pix_valid), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule